// File: doc/BRIEF.md
# Paged data address translator

This block widens a 16-bit virtual data address into a 22-bit physical address. It holds four 8-bit frame registers. The top two bits of the virtual address pick one of them. The chosen register's contents become the upper physical address bits, and the low fourteen bits pass through unchanged. Each register therefore maps one 16-Kbyte quarter of the virtual space onto any of 256 physical 16-Kbyte frames.

The CPU reaches the four registers through a small register-file port. That port carries a register page number, an 8-bit register address, write and read enables, and write and read data. The registers respond only while register page 21 is selected. A run-time relocation input chooses between two address windows. With relocation clear the registers sit at addresses 240 to 243. With relocation set they sit at 224 to 227, and the upper window no longer responds. The frame registers hold no guaranteed value until they are written. A synchronous reset clears them, but software must not depend on that.

The translation port is purely combinational. A write to a frame register shows up in translations from the cycle after its clock edge.

Top module: `dxl_translator`

## Requirements
- R1: Each of the four 8-bit frame registers is written with `reg_wdata` on the rising clock edge when a write hits it. It then reads back the written value.
- R2: With `reloc_en` low and `reg_page` = 21, register addresses 240, 241, 242 and 243 select frame registers 0, 1, 2 and 3, for both write and read.
- R3: With `reloc_en` high and `reg_page` = 21, addresses 224, 225, 226 and 227 select frame registers 0 to 3. Addresses 240 to 243 then hit nothing: a read there returns 0 and a write there changes no register.
- R4: When `reg_page` is any value other than 21, no register is hit, whatever the address.
- R5: A write that hits no frame register leaves all four registers unchanged.
- R6: `reg_rdata` returns the addressed register combinationally when `reg_re` is high and the access hits. Otherwise it is 0.
- R7: When `va_strobe` is high, `pa[21:14]` equals frame register n, where n = `va[15:14]`.
- R8: When `va_strobe` is high, `pa[13:0]` equals `va[13:0]`.
- R9: When `va_strobe` is low, `pa` is 0.
- R10: Translation in the cycle of a write edge uses the old register value. From the next cycle it uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| reloc_en | input | 1 | Selects the lower register window (224 to 227) when high |
| reg_page | input | 8 | Current register page number |
| reg_addr | input | 8 | Register-file address |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, 0 on a miss |
| va | input | 16 | Virtual data address |
| va_strobe | input | 1 | Data access strobe |
| pa | output | 22 | Physical data address, 0 when the strobe is low |

## Verification
The hardest case to reach is a write that lands in the window that is currently inactive, or on the wrong register page. Nothing changes at the ports at that moment. The fault only shows up if the other window is later read back, or if the register is later used for translation. Directed sequences therefore write to the stale window with relocation set, and to page 20, then read the live window and translate through each quarter. The random phase biases addresses toward both windows and toggles relocation and the page number. A reference model catches any stray write, whenever it is used later. A separate directed case translates through a register in the very cycle it is rewritten, to pin down when the new value takes effect.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    localparam int VA_W      = 16;
    localparam int PG_W      = 8;
    localparam int RA_W      = 8;
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int OFF_W     = VA_W - SEL_W;
    localparam int PA_W      = PG_W + OFF_W;

    localparam logic [PG_W-1:0] REG_PAGE_ID   = 8'd21;
    localparam logic [RA_W-1:0] WIN_BASE_HIGH = 8'd240;
    localparam logic [RA_W-1:0] WIN_BASE_LOW  = 8'd224;

    typedef logic [PG_W-1:0]  frame_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic hit;
        sel_t idx;
    } dec_t;

    typedef struct packed {
        frame_t             frame;
        logic [OFF_W-1:0]   offset;
    } pa_t;

    function automatic logic [RA_W-1:0] window_base(input logic reloc);
        return reloc ? WIN_BASE_LOW : WIN_BASE_HIGH;
    endfunction

endpackage

// File: rtl/dxl_reg_decode.sv
module dxl_reg_decode
    import dxl_pkg::*;
(
    input  logic                reloc_en,
    input  logic [PG_W-1:0]     reg_page,
    input  logic [RA_W-1:0]     reg_addr,
    output logic [NUM_REGS-1:0] hit_vec,
    output dec_t                dec
);

    logic            page_ok;
    logic [RA_W-1:0] base;

    assign page_ok = (reg_page == REG_PAGE_ID);
    assign base    = window_base(reloc_en);

    // One comparator per frame register against its slot in the live window
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        assign hit_vec[g] = page_ok && (reg_addr == (base + RA_W'(g)));
    end

    always_comb begin
        dec.hit = |hit_vec;
        dec.idx = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit_vec[i]) dec.idx = sel_t'(i);
        end
    end

endmodule

// File: rtl/dxl_page_bank.sv
module dxl_page_bank
    import dxl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_REGS-1:0]      wr_vec,
    input  frame_t                   wdata,
    input  logic                     rd_en,
    input  sel_t                     rd_idx,
    output frame_t                   rdata,
    output logic [NUM_REGS*PG_W-1:0] bank_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        frame_t q;
        always_ff @(posedge clk) begin
            if (rst)            q <= '0;
            else if (wr_vec[g]) q <= wdata;
        end
        assign bank_flat[g*PG_W +: PG_W] = q;
    end

    assign rdata = rd_en ? bank_flat[rd_idx*PG_W +: PG_W] : '0;

endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate
    import dxl_pkg::*;
(
    input  logic [VA_W-1:0]          va,
    input  logic                     va_strobe,
    input  logic [NUM_REGS*PG_W-1:0] bank_flat,
    output logic [PA_W-1:0]          pa
);

    sel_t quarter;
    pa_t  xl;

    assign quarter   = va[VA_W-1 -: SEL_W];
    assign xl.frame  = bank_flat[quarter*PG_W +: PG_W];
    assign xl.offset = va[OFF_W-1:0];
    assign pa        = va_strobe ? xl : '0;

endmodule

// File: rtl/dxl_translator.sv
module dxl_translator
    import dxl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reloc_en,
    input  logic [7:0]       reg_page,
    input  logic [7:0]       reg_addr,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [15:0]      va,
    input  logic             va_strobe,
    output logic [21:0]      pa
);

    logic [NUM_REGS-1:0]      hit_vec;
    dec_t                     dec;
    logic [NUM_REGS-1:0]      wr_vec;
    logic [NUM_REGS*PG_W-1:0] bank_flat;

    dxl_reg_decode u_dec (
        .reloc_en (reloc_en),
        .reg_page (reg_page),
        .reg_addr (reg_addr),
        .hit_vec  (hit_vec),
        .dec      (dec)
    );

    assign wr_vec = reg_we ? hit_vec : '0;

    dxl_page_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_vec    (wr_vec),
        .wdata     (reg_wdata),
        .rd_en     (reg_re && dec.hit),
        .rd_idx    (dec.idx),
        .rdata     (reg_rdata),
        .bank_flat (bank_flat)
    );

    dxl_xlate u_xl (
        .va        (va),
        .va_strobe (va_strobe),
        .bank_flat (bank_flat),
        .pa        (pa)
    );

endmodule

// File: rtl/dxl_translator_chk.sv
module dxl_translator_chk
    import dxl_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     reloc_en,
    input logic [7:0]               reg_page,
    input logic [7:0]               reg_addr,
    input logic                     reg_we,
    input logic                     reg_re,
    input logic [7:0]               reg_wdata,
    input logic [7:0]               reg_rdata,
    input logic [15:0]              va,
    input logic                     va_strobe,
    input logic [21:0]              pa,
    input logic [NUM_REGS*PG_W-1:0] bank_flat
);

    function automatic frame_t slot(input logic [NUM_REGS*PG_W-1:0] b, input sel_t i);
        return b[i*PG_W +: PG_W];
    endfunction

    logic page_ok, in_high, in_low, chk_hit;
    assign page_ok = (reg_page == 8'd21);
    assign in_high = (reg_addr >= 8'd240) && (reg_addr <= 8'd243);
    assign in_low  = (reg_addr >= 8'd224) && (reg_addr <= 8'd227);
    assign chk_hit = page_ok && (reloc_en ? in_low : in_high);

    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        reg_we && chk_hit |=> slot(bank_flat, $past(reg_addr[1:0])) == $past(reg_wdata));

    p_read_hit_r2: assert property (@(posedge clk) disable iff (rst)
        reg_re && chk_hit |-> reg_rdata == slot(bank_flat, reg_addr[1:0]));

    p_stale_window_r3: assert property (@(posedge clk) disable iff (rst)
        reloc_en && reg_re && page_ok && in_high |-> reg_rdata == 8'd0);

    p_wrong_page_r4: assert property (@(posedge clk) disable iff (rst)
        reg_we && !page_ok |=> $stable(bank_flat));

    p_miss_hold_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we && !chk_hit |=> $stable(bank_flat));

    p_read_miss_r6: assert property (@(posedge clk) disable iff (rst)
        !(reg_re && chk_hit) |-> reg_rdata == 8'd0);

    p_frame_r7: assert property (@(posedge clk) disable iff (rst)
        va_strobe |-> pa[21:14] == slot(bank_flat, va[15:14]));

    p_offset_r8: assert property (@(posedge clk) disable iff (rst)
        va_strobe |-> pa[13:0] == va[13:0]);

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !va_strobe |-> pa == 22'd0);

endmodule

bind dxl_translator dxl_translator_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .reloc_en  (reloc_en),
    .reg_page  (reg_page),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .va        (va),
    .va_strobe (va_strobe),
    .pa        (pa),
    .bank_flat (bank_flat)
);

// File: tb/dxl_translator_tb_top.sv
module dxl_translator_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reloc_en;
    logic [7:0]  reg_page, reg_addr, reg_wdata, reg_rdata;
    logic        reg_we, reg_re;
    logic [15:0] va;
    logic        va_strobe;
    logic [21:0] pa;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] mdl [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dxl_translator dut_i (
        .clk(clk), .rst(rst), .reloc_en(reloc_en), .reg_page(reg_page),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .va(va), .va_strobe(va_strobe), .pa(pa)
    );

    function automatic logic exp_hit(input logic [7:0] pg, input logic [7:0] ad, input logic rl);
        logic [7:0] b;
        b = rl ? 8'd224 : 8'd240;
        return (pg == 8'd21) && (ad >= b) && (ad <= b + 8'd3);
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [7:0] pg, input logic [7:0] ad,
                                             input logic rl, input logic re);
        return (re && exp_hit(pg, ad, rl)) ? mdl[ad[1:0]] : 8'd0;
    endfunction

    function automatic logic [21:0] exp_pa(input logic [15:0] v, input logic s);
        return s ? {mdl[v[15:14]], v[13:0]} : 22'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, check combinational outputs, then commit at the rising edge
    task automatic apply(input string tag, input logic rl, input logic [7:0] pg,
                         input logic [7:0] ad, input logic we, input logic re,
                         input logic [7:0] wd, input logic [15:0] v, input logic s);
        @(negedge clk);
        reloc_en = rl; reg_page = pg; reg_addr = ad; reg_we = we; reg_re = re;
        reg_wdata = wd; va = v; va_strobe = s;
        #1;
        check({tag, " rdata"}, 32'(reg_rdata), 32'(exp_rdata(pg, ad, rl, re)));
        check({tag, " pa"},    32'(pa),        32'(exp_pa(v, s)));
        @(posedge clk);
        if (we && exp_hit(pg, ad, rl)) mdl[ad[1:0]] = wd;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < 4; i++) mdl[i] = 8'd0;
        rst = 1'b1; reloc_en = 1'b0; reg_page = 8'd0; reg_addr = 8'd0;
        reg_we = 1'b0; reg_re = 1'b0; reg_wdata = 8'd0; va = 16'd0; va_strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset rdata", 32'(reg_rdata), 32'd0);
        check("R9 reset pa", 32'(pa), 32'd0);
        rst = 1'b0;

        // R2: load every frame register through the upper window
        for (int i = 0; i < 4; i++)
            apply("R2 write", 1'b0, 8'd21, 8'(240 + i), 1'b1, 1'b0, 8'(8'h1B * (i + 1)), 16'd0, 1'b0);
        for (int i = 0; i < 4; i++)
            apply("R2 read", 1'b0, 8'd21, 8'(240 + i), 1'b0, 1'b1, 8'd0, 16'd0, 1'b0);
        // R7 R8: one translation per quarter
        for (int i = 0; i < 4; i++)
            apply("R7 R8 quarter", 1'b0, 8'd21, 8'd0, 1'b0, 1'b0, 8'd0,
                  {2'(i), 14'h2A5C}, 1'b1);
        apply("R9 strobe low", 1'b0, 8'd21, 8'd0, 1'b0, 1'b0, 8'd0, 16'hFFFF, 1'b0);

        // R3: relocated window
        apply("R3 low write", 1'b1, 8'd21, 8'd226, 1'b1, 1'b0, 8'hA5, 16'd0, 1'b0);
        apply("R3 low read", 1'b1, 8'd21, 8'd226, 1'b0, 1'b1, 8'd0, 16'h8001, 1'b1);
        apply("R3 stale read", 1'b1, 8'd21, 8'd242, 1'b0, 1'b1, 8'd0, 16'd0, 1'b0);
        apply("R3 R5 stale write", 1'b1, 8'd21, 8'd241, 1'b1, 1'b0, 8'hEE, 16'd0, 1'b0);
        apply("R3 R5 readback", 1'b1, 8'd21, 8'd225, 1'b0, 1'b1, 8'd0, 16'h4000, 1'b1);
        apply("R5 low window idle", 1'b0, 8'd21, 8'd225, 1'b1, 1'b1, 8'h77, 16'd0, 1'b0);
        apply("R5 readback", 1'b0, 8'd21, 8'd241, 1'b0, 1'b1, 8'd0, 16'h7FFF, 1'b1);

        // R4: wrong register page
        apply("R4 page 20 write", 1'b0, 8'd20, 8'd240, 1'b1, 1'b1, 8'h99, 16'd0, 1'b0);
        apply("R4 readback", 1'b0, 8'd21, 8'd240, 1'b0, 1'b1, 8'd0, 16'h0123, 1'b1);

        // R10: translate in the write cycle, then the cycle after
        apply("R10 same cycle", 1'b0, 8'd21, 8'd243, 1'b1, 1'b1, 8'h3C, 16'hC123, 1'b1);
        apply("R10 next cycle", 1'b0, 8'd21, 8'd243, 1'b0, 1'b1, 8'd0, 16'hC123, 1'b1);

        // R1: random mix
        for (int n = 0; n < 3000; n++) begin
            logic       rl, we, re, s;
            logic [7:0] pg, ad;
            logic [1:0] k;
            rl = 1'($urandom);
            pg = ($urandom % 4 != 0) ? 8'd21 : 8'($urandom);
            k  = 2'($urandom);
            case ($urandom % 4)
                0: ad = 8'd240 + 8'(k);
                1: ad = 8'd224 + 8'(k);
                2: ad = 8'($urandom);
                default: ad = 8'd244 + 8'(k);
            endcase
            we = 1'($urandom);
            re = 1'($urandom);
            s  = ($urandom % 4 != 0);
            apply("R1 R6 R7 random", rl, pg, ad, we, re, 8'($urandom), 16'($urandom), s);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule